// File: doc/BRIEF.md
# Self-Clearing Command Trigger Register

This block turns writes to one 16-bit command word into the actions of a converter-style device. Some fields are keyed: a 4-bit software-reset field and a 4-bit unlock field act only on one exact pattern each. Other bits are one-shot triggers: configuration reset, non-volatile reload and non-volatile program. Two bits request a ramp of the output code toward a margin target. Two bits are plain enable levels. Each accepted action produces a single-cycle pulse for the logic that carries it out.

The non-volatile commands set a busy flag. The flag is held until the storage controller reports completion, and new non-volatile commands are refused while it is set. A margin request stays active until the ramp logic reports that the output code equals its target. When the lock input is high, only writes that carry the unlock pattern are accepted.

Top module: `cmd_trigger_reg`

## Requirements
- R1: While reset is asserted, and just after it is released, every pulse output, `nvm_busy`, both margin-active levels and both enable levels are 0.
- R2: While `lock_in` is 1, a write whose bits [15:12] are not 4'b0101 has no effect on any output.
- R3: A write whose bits [15:12] equal 4'b0101 is accepted even while `lock_in` is 1. All of its other fields take effect.
- R4: An accepted write with bits [3:0] equal to 4'b1010 pulses `sw_reset_pulse`. Any other value in that field gives no pulse. The software reset clears both enable levels and both margin-active levels, and it overrides any enable or margin bit carried in the same write.
- R5: An accepted write with bit 9 set pulses `cfg_reset_pulse`. It clears the enables and the margin levels in the same way as R4.
- R6: An accepted write with bit 5 set pulses `nvm_reload_pulse`, and one with bit 4 set pulses `nvm_prog_pulse`. Either pulse sets `nvm_busy`, which stays 1 until a cycle in which `nvm_done` is 1. If both bits are set, only the reload is started.
- R7: Bits 5 and 4 are ignored in a write that arrives while `nvm_busy` is 1: no pulse is produced and `nvm_busy` is unchanged.
- R8: Bit 7 pulses `margin_hi_pulse` and sets `margin_hi_active`, which clears in the cycle after `at_target` is 1. It also cancels any low request.
- R9: Bit 6 pulses `margin_lo_pulse` and sets `margin_lo_active`. It cancels any high request. If bits 7 and 6 are both set, only the high request is taken.
- R10: Every accepted write loads `wavegen_en` from bit 8 and `gpi_en` from bit 10. Bit 11 has no effect.
- R11: Every pulse output lasts exactly one cycle. It is high in the cycle after the clock edge that samples the accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 16 | Command word |
| lock_in | input | 1 | Device lock; blocks writes that lack the unlock key |
| nvm_done | input | 1 | Completion strobe from the non-volatile controller |
| at_target | input | 1 | Output code has reached the active margin target |
| sw_reset_pulse | output | 1 | Software reset action |
| cfg_reset_pulse | output | 1 | Factory configuration reset action |
| nvm_reload_pulse | output | 1 | Start non-volatile reload |
| nvm_prog_pulse | output | 1 | Start non-volatile program |
| margin_hi_pulse | output | 1 | Start ramp toward the high margin |
| margin_lo_pulse | output | 1 | Start ramp toward the low margin |
| nvm_busy | output | 1 | Non-volatile operation in progress |
| margin_hi_active | output | 1 | High margin request pending |
| margin_lo_active | output | 1 | Low margin request pending |
| wavegen_en | output | 1 | Continuous waveform enable level |
| gpi_en | output | 1 | General-purpose input enable level |

## Verification
A busy flag stuck high shows up as a missing non-volatile pulse on the next command. A busy flag that drops early shows up as an extra pulse. Both appear one cycle after the write. A wrong margin state shows at the ports either as both active levels high together or as an active level that outlives `at_target` by more than one cycle. A faulty key compare or lock gate changes the pulse or level outputs in the cycle right after the offending write, so each fault is visible within one clock.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    localparam int REG_W = 16;
    localparam int KEY_W = 4;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 4'b0101;
    localparam logic [KEY_W-1:0] SWRST_KEY  = 4'b1010;
    // bit positions inside the command word
    localparam int UNLOCK_LSB = 12;
    localparam int GPI_BIT    = 10;
    localparam int CFGRST_BIT = 9;
    localparam int WAVE_BIT   = 8;
    localparam int MHI_BIT    = 7;
    localparam int MLO_BIT    = 6;
    localparam int RELOAD_BIT = 5;
    localparam int PROG_BIT   = 4;
    localparam int SWRST_LSB  = 0;

    typedef struct packed {
        logic sw_rst;
        logic cfg_rst;
        logic reload;
        logic prog;
        logic mhi;
        logic mlo;
        logic wave_en;
        logic gpi_en;
    } cmd_t;
endpackage

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
    import cmdreg_pkg::*;
(
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock_in,
    output logic             accept,
    output cmd_t             cmd
);
    logic key_ok;
    logic any_rst;
    logic unused_spare_bits;

    assign unused_spare_bits = wr_data[11];

    always_comb begin
        key_ok  = (wr_data[UNLOCK_LSB +: KEY_W] == UNLOCK_KEY);
        accept  = wr_en && (!lock_in || key_ok);
        any_rst = (wr_data[SWRST_LSB +: KEY_W] == SWRST_KEY) || wr_data[CFGRST_BIT];

        cmd.sw_rst  = wr_data[SWRST_LSB +: KEY_W] == SWRST_KEY;
        cmd.cfg_rst = wr_data[CFGRST_BIT];
        cmd.reload  = wr_data[RELOAD_BIT];
        cmd.prog    = wr_data[PROG_BIT] && !wr_data[RELOAD_BIT];
        // a reset in the same word overrides margin and enable bits
        cmd.mhi     = wr_data[MHI_BIT] && !any_rst;
        cmd.mlo     = wr_data[MLO_BIT] && !wr_data[MHI_BIT] && !any_rst;
        cmd.wave_en = wr_data[WAVE_BIT] && !any_rst;
        cmd.gpi_en  = wr_data[GPI_BIT] && !any_rst;
    end
endmodule

// File: rtl/cmdreg_nvm_ctrl.sv
module cmdreg_nvm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_reload,
    input  logic req_prog,
    input  logic done,
    output logic reload_pulse,
    output logic prog_pulse,
    output logic busy
);
    typedef struct packed {
        logic busy;
        logic reload_p;
        logic prog_p;
    } nvm_st_t;

    nvm_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.reload_p = 1'b0;
        st_d.prog_p   = 1'b0;
        if (st_q.busy) begin
            if (done) st_d.busy = 1'b0;
        end else if (req_reload) begin
            st_d.reload_p = 1'b1;
            st_d.busy     = 1'b1;
        end else if (req_prog) begin
            st_d.prog_p = 1'b1;
            st_d.busy   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reload_pulse = st_q.reload_p;
    assign prog_pulse   = st_q.prog_p;
    assign busy         = st_q.busy;

    // R6: a start pulse always comes with the busy flag
    a_r6_pulse_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_pulse || prog_pulse) |-> busy);
    // R6: never both operations at once
    a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reload_pulse, prog_pulse}));
    // R7: no new start while already busy
    a_r7_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(reload_pulse || prog_pulse));
endmodule

// File: rtl/cmdreg_margin_ctrl.sv
module cmdreg_margin_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    input  logic clear,
    input  logic at_target,
    output logic hi_pulse,
    output logic lo_pulse,
    output logic hi_active,
    output logic lo_active
);
    typedef struct packed {
        logic hi_act;
        logic lo_act;
        logic hi_p;
        logic lo_p;
    } mrg_st_t;

    mrg_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hi_p = 1'b0;
        st_d.lo_p = 1'b0;
        if (at_target) begin
            st_d.hi_act = 1'b0;
            st_d.lo_act = 1'b0;
        end
        if (clear) begin
            st_d.hi_act = 1'b0;
            st_d.lo_act = 1'b0;
        end else if (req_hi) begin
            st_d.hi_act = 1'b1;
            st_d.lo_act = 1'b0;
            st_d.hi_p   = 1'b1;
        end else if (req_lo) begin
            st_d.lo_act = 1'b1;
            st_d.hi_act = 1'b0;
            st_d.lo_p   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_pulse  = st_q.hi_p;
    assign lo_pulse  = st_q.lo_p;
    assign hi_active = st_q.hi_act;
    assign lo_active = st_q.lo_act;

    // R9: high and low requests are never pending together
    a_r9_margin_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_active && lo_active));
    // R8: reaching the target without a new request ends the high request
    a_r8_target_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (at_target && !req_hi && !req_lo) |=> !hi_active && !lo_active);
    // R8: a pulse always starts a pending request
    a_r8_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        hi_pulse |-> hi_active);
endmodule

// File: rtl/cmd_trigger_reg.sv
module cmd_trigger_reg
    import cmdreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock_in,
    input  logic             nvm_done,
    input  logic             at_target,
    output logic             sw_reset_pulse,
    output logic             cfg_reset_pulse,
    output logic             nvm_reload_pulse,
    output logic             nvm_prog_pulse,
    output logic             margin_hi_pulse,
    output logic             margin_lo_pulse,
    output logic             nvm_busy,
    output logic             margin_hi_active,
    output logic             margin_lo_active,
    output logic             wavegen_en,
    output logic             gpi_en
);
    typedef struct packed {
        logic sw_p;
        logic cfg_p;
        logic wave;
        logic gpi;
    } top_st_t;

    logic    accept;
    cmd_t    cmd;
    top_st_t st_d, st_q;

    cmdreg_decode u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .lock_in (lock_in),
        .accept  (accept),
        .cmd     (cmd)
    );

    cmdreg_nvm_ctrl u_nvm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_reload   (accept && cmd.reload),
        .req_prog     (accept && cmd.prog),
        .done         (nvm_done),
        .reload_pulse (nvm_reload_pulse),
        .prog_pulse   (nvm_prog_pulse),
        .busy         (nvm_busy)
    );

    cmdreg_margin_ctrl u_mrg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_hi    (accept && cmd.mhi),
        .req_lo    (accept && cmd.mlo),
        .clear     (accept && (cmd.sw_rst || cmd.cfg_rst)),
        .at_target (at_target),
        .hi_pulse  (margin_hi_pulse),
        .lo_pulse  (margin_lo_pulse),
        .hi_active (margin_hi_active),
        .lo_active (margin_lo_active)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sw_p  = accept && cmd.sw_rst;
        st_d.cfg_p = accept && cmd.cfg_rst;
        if (accept) begin
            st_d.wave = cmd.wave_en;
            st_d.gpi  = cmd.gpi_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_reset_pulse  = st_q.sw_p;
    assign cfg_reset_pulse = st_q.cfg_p;
    assign wavegen_en      = st_q.wave;
    assign gpi_en          = st_q.gpi;

    // R2: a locked write without the key produces no action
    a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock_in && wr_data[15:12] != 4'b0101) |=>
        !(sw_reset_pulse || cfg_reset_pulse || nvm_reload_pulse || nvm_prog_pulse
          || margin_hi_pulse || margin_lo_pulse));
    // R11: reset pulses follow a write strobe by one cycle
    a_r11_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_reset_pulse || cfg_reset_pulse) |-> $past(wr_en));
    // R4: after a software reset the enable levels are cleared
    a_r4_reset_clears_levels: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset_pulse |-> !wavegen_en && !gpi_en && !margin_hi_active && !margin_lo_active);
endmodule

// File: tb/sim_cmd_trigger_reg.sv
module sim_cmd_trigger_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        lock_in = 1'b0;
    logic        nvm_done = 1'b0;
    logic        at_target = 1'b0;
    logic        sw_reset_pulse, cfg_reset_pulse, nvm_reload_pulse, nvm_prog_pulse;
    logic        margin_hi_pulse, margin_lo_pulse, nvm_busy;
    logic        margin_hi_active, margin_lo_active, wavegen_en, gpi_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    cmd_trigger_reg u0 (.*);

    // pulses {sw,cfg,reload,prog,hi,lo}; levels {busy,hi_act,lo_act,wave,gpi}
    function automatic logic [5:0] pulses();
        return {sw_reset_pulse, cfg_reset_pulse, nvm_reload_pulse, nvm_prog_pulse,
                margin_hi_pulse, margin_lo_pulse};
    endfunction
    function automatic logic [4:0] levels();
        return {nvm_busy, margin_hi_active, margin_lo_active, wavegen_en, gpi_en};
    endfunction

    task automatic check(input string req, input logic [5:0] ep, input logic [4:0] el);
        n_chk++;
        if (pulses() !== ep || levels() !== el) begin
            n_bad++;
            $display("FAIL %s pulses=%b levels=%b expected pulses=%b levels=%b",
                     req, pulses(), levels(), ep, el);
        end
    endtask

    // write during one cycle; check right after the sampling edge, then one cycle later
    task automatic do_write(input logic lk, input logic [15:0] d, input string req,
                            input logic [5:0] ep, input logic [4:0] el);
        @(negedge clk);
        lock_in = lk; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        check(req, ep, el);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk); #1;
        check({req, " R11 one-cycle"}, 6'b0, el);
    endtask

    typedef struct packed {
        logic        lk;
        logic [15:0] d;
        logic [5:0]  ep;
        logic [4:0]  el;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0500, 6'b000000, 5'b00011},  // R10 enables
        '{1'b0, 16'h0800, 6'b000000, 5'b00000},  // R10 bit 11 ignored
        '{1'b1, 16'h0100, 6'b000000, 5'b00000},  // R2 locked
        '{1'b1, 16'h5100, 6'b000000, 5'b00010},  // R3 key
        '{1'b1, 16'h3400, 6'b000000, 5'b00010},  // R2 wrong key
        '{1'b0, 16'h0180, 6'b000010, 5'b01010},  // R8 high
        '{1'b0, 16'h01C0, 6'b000010, 5'b01010},  // R9 both, high wins
        '{1'b0, 16'h0140, 6'b000001, 5'b00110},  // R9 low cancels high
        '{1'b0, 16'h0009, 6'b000000, 5'b00100},  // R4 wrong reset key
        '{1'b0, 16'h058A, 6'b100000, 5'b00000},  // R4 reset wins
        '{1'b0, 16'h0500, 6'b000000, 5'b00011},  // R10
        '{1'b0, 16'h0200, 6'b010000, 5'b00000},  // R5 config reset
        '{1'b1, 16'h000A, 6'b000000, 5'b00000},  // R2 locked reset
        '{1'b1, 16'h500A, 6'b100000, 5'b00000}   // R3 unlocked reset
    };

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 6'b0, 5'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after release", 6'b0, 5'b0);

        for (int i = 0; i < NV; i++)
            do_write(VECS[i].lk, VECS[i].d, $sformatf("vector %0d R2-R10 table", i),
                     VECS[i].ep, VECS[i].el);

        // R6 reload, R7 ignored while busy
        do_write(1'b0, 16'h0020, "R6 reload", 6'b001000, 5'b10000);
        do_write(1'b0, 16'h0010, "R7 prog while busy", 6'b000000, 5'b10000);
        do_write(1'b0, 16'h0020, "R7 reload while busy", 6'b000000, 5'b10000);
        @(negedge clk); nvm_done = 1'b1;
        @(posedge clk); #1;
        check("R6 done clears busy", 6'b0, 5'b00000);
        @(negedge clk); nvm_done = 1'b0;
        do_write(1'b0, 16'h0030, "R6 both, reload wins", 6'b001000, 5'b10000);
        @(negedge clk); nvm_done = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); nvm_done = 1'b0;
        do_write(1'b0, 16'h0010, "R6 program", 6'b000100, 5'b10000);
        @(negedge clk); nvm_done = 1'b1;
        @(posedge clk); #1;
        check("R6 program done", 6'b0, 5'b00000);
        @(negedge clk); nvm_done = 1'b0;

        // R8 target reached clears the request
        do_write(1'b0, 16'h0080, "R8 high again", 6'b000010, 5'b01000);
        @(posedge clk); #1;
        check("R8 held without target", 6'b0, 5'b01000);
        @(negedge clk); at_target = 1'b1;
        @(posedge clk); #1;
        check("R8 target clears", 6'b0, 5'b00000);
        @(negedge clk); at_target = 1'b0;

        // R1 reset in mid-run
        do_write(1'b0, 16'h05C0, "R10 before reset", 6'b000010, 5'b01011);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 mid-run reset", 6'b0, 5'b0);
        @(negedge clk); rst_n = 1'b1;
        done_flag = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete (expected completion)");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule